// File: doc/BRIEF.md
# Up-Down PWM Generator with Shadowed Compare

This block drives two complementary PWM outputs from a symmetric time-base counter. The counter climbs from zero to a programmed period, then falls back to zero. The system clock is divided down by two cascaded power-of-two prescalers to make the count tick. Each output has an action rule at the compare match, and the rule depends on whether the counter is rising or falling. Output A rises on the upward match and drops on the downward match. Output B does the reverse. The result is a centre-aligned waveform whose high time shrinks as the compare value grows.

Software programs the block through a small write port. Period and compare writes land in holding registers. They reach the working copies only when the counter sits at zero, so a pulse never gets cut short or doubled in the middle of a cycle. The block emits a one-cycle strobe when the counter leaves zero and another when it turns at the peak. An interrupt request pulses on every Nth zero strobe.

Top module: `updown_pwm`

## Requirements
- R1: After reset, pwm_a and pwm_b are both 0, and zero_evt, prd_evt and irq are 0 until the first time-base tick.
- R2: With period P > 0, zero_evt pulses once every 2*P time-base ticks. prd_evt pulses exactly P ticks after each zero_evt pulse.
- R3: With compare C where 0 < C < P, pwm_a goes to 1 after the upward match and to 0 after the downward match. It is therefore high for 2*(P-C) ticks per cycle.
- R4: pwm_b is 0 after the upward match and 1 after the downward match. It equals the inverse of pwm_a once the first match has happened.
- R5: A write to address 1 (compare) is held in a holding register. It takes effect only at the next counter-zero tick, so the cycle in progress keeps the old duty.
- R6: A write to address 0 (period) is held in a holding register and takes effect only at counter zero. The cycle in progress completes with the old period, and the counter never exceeds the working period.
- R7: A write to address 2 sets the prescaler: bits [2:0] select stage one as 2^s1 and bits [5:3] select stage two as 2^s2. One tick occurs every 2^(s1+s2) clocks. The reset value is s1=s2=2 (divide by 16). A write to address 2 restarts both prescaler stages.
- R8: Address 3 holds N (reset value 3). irq pulses together with every Nth zero_evt pulse. N=0 disables the pulse.
- R9: If the working compare value is 0 or is at least P, no match occurs and pwm_a and pwm_b hold their levels.
- R10: The period resets to 6000 and the compare to 3000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1 compare, 2 prescaler, 3 interrupt divider |
| wr_data | input | CW | Write data |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B, complementary to A |
| zero_evt | output | 1 | One-cycle strobe at the counter-zero tick |
| prd_evt | output | 1 | One-cycle strobe at the counter-peak tick |
| irq | output | 1 | One-cycle interrupt pulse on every Nth zero strobe |

## Verification
Duty is measured for compare values near the bottom, the middle and the top of the period, and for two different periods. This separates a correct slope-dependent action from swapped or slope-blind rules, and a correct turnaround from an off-by-one at the peak. Writes are issued in the middle of a cycle so the old and new values can both be seen. The bench checks that the cycle in progress keeps the old timing and the next cycle shows the new timing. This tells a holding register apart from a direct write. Several prescaler splits with the same total ratio and with different ratios are measured to expose a swapped or mis-weighted stage. Compare values of 0, equal to the period and above it confirm that the outputs freeze. Interrupt divider values of 1, 2 and 3 confirm the zero-event count.

// File: rtl/updown_pwm.sv
module updown_pwm #(
  parameter int CW = 16,
  parameter int PSW = 3,
  parameter int NW = 4,
  parameter logic [CW-1:0] PRD_RST = 16'd6000,
  parameter logic [CW-1:0] CMP_RST = 16'd3000,
  parameter logic [PSW-1:0] DIV_RST = 3'd2,
  parameter logic [NW-1:0] N_RST = 4'd3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic          zero_evt,
  output logic          prd_evt,
  output logic          irq
);
  localparam int PCW = (1 << PSW) - 1;

  logic [CW-1:0] prd_sh, cmp_sh, prd_act, cmp_act, cnt;
  logic [PSW-1:0] s1, s2;
  logic [PCW-1:0] c1, c2, m1, m2;
  logic [NW-1:0] nsel, zcnt;
  logic up, acted;

  wire wr_div = wr_en && wr_addr == 2'd2;
  assign m1 = ~({PCW{1'b1}} << s1);
  assign m2 = ~({PCW{1'b1}} << s2);
  wire tick1 = c1 == m1;
  wire tb_tick = tick1 && c2 == m2;
  wire zero_tick = tb_tick && cnt == '0;
  wire peak_tick = tb_tick && up && cnt != '0 && cnt == prd_act;
  wire match = tb_tick && cmp_act != '0 && cmp_act < prd_act && cnt == cmp_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_sh <= PRD_RST;
      cmp_sh <= CMP_RST;
      s1 <= DIV_RST;
      s2 <= DIV_RST;
      nsel <= N_RST;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: prd_sh <= wr_data;
        2'd1: cmp_sh <= wr_data;
        2'd2: begin
          s1 <= wr_data[PSW-1:0];
          s2 <= wr_data[2*PSW-1:PSW];
        end
        default: nsel <= wr_data[NW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wr_div) begin
      c1 <= '0;
      c2 <= '0;
    end else begin
      c1 <= tick1 ? '0 : c1 + 1'b1;
      if (tb_tick) c2 <= '0;
      else if (tick1) c2 <= c2 + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      up <= 1'b1;
      prd_act <= PRD_RST;
      cmp_act <= CMP_RST;
    end else if (tb_tick) begin
      if (cnt == '0) begin
        prd_act <= prd_sh;
        cmp_act <= cmp_sh;
        up <= 1'b1;
        cnt <= (prd_sh != '0) ? CW'(1) : '0;
      end else if (up && cnt >= prd_act) begin
        up <= 1'b0;
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= up ? cnt + 1'b1 : cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_a <= 1'b0;
      pwm_b <= 1'b0;
      acted <= 1'b0;
    end else if (match) begin
      pwm_a <= up;
      pwm_b <= !up;
      acted <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zero_evt <= 1'b0;
      prd_evt <= 1'b0;
      irq <= 1'b0;
      zcnt <= '0;
    end else begin
      zero_evt <= zero_tick;
      prd_evt <= peak_tick;
      irq <= 1'b0;
      if (zero_tick) begin
        if (nsel != '0 && zcnt + 1'b1 >= nsel) begin
          zcnt <= '0;
          irq <= 1'b1;
        end else begin
          zcnt <= zcnt + 1'b1;
        end
      end
    end
  end

  AST_OUT_COMPL: assert property (@(posedge clk) disable iff (!rst_n) acted |-> pwm_a != pwm_b); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= prd_act); // R6
  AST_CMP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !$stable(cmp_act) |-> zero_evt); // R5
  AST_PRD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !$stable(prd_act) |-> zero_evt); // R6
  AST_IRQ_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n) irq |-> zero_evt); // R8
  AST_EVT_APART: assert property (@(posedge clk) disable iff (!rst_n) !(zero_evt && prd_evt)); // R2
endmodule

// File: tb/updown_pwm_test.sv
module updown_pwm_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic pwm_a, pwm_b, zero_evt, prd_evt, irq;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  updown_pwm uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b), .zero_evt(zero_evt),
    .prd_evt(prd_evt), .irq(irq));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_zero();
    do @(negedge clk); while (!zero_evt);
  endtask

  task automatic meas(input int wk, input logic [1:0] wa, input logic [15:0] wd,
                      output int gap, output int ah, output int bh, output int bm, output int pg);
    gap = 0; ah = 0; bh = 0; bm = 0; pg = -1;
    do begin
      if (gap == wk) begin wr_en = 1'b1; wr_addr = wa; wr_data = wd; end
      else wr_en = 1'b0;
      @(negedge clk);
      gap++;
      if (pwm_a) ah++;
      if (pwm_b) bh++;
      if (pwm_a == pwm_b) bm++;
      if (prd_evt) pg = gap;
    end while (!zero_evt);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk("R1 pwm_a", pwm_a, 0);
    chk("R1 pwm_b", pwm_b, 0);
    chk("R1 zero_evt", zero_evt, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_duty(input int p, input int c);
    int g, ah, bh, bm, pg;
    wr(2'd0, 16'(p));
    wr(2'd1, 16'(c));
    meas(-1, 0, 0, g, ah, bh, bm, pg);
    meas(-1, 0, 0, g, ah, bh, bm, pg);
    meas(-1, 0, 0, g, ah, bh, bm, pg);
    chk($sformatf("R2 gap p=%0d", p), g, 2 * p);
    chk($sformatf("R2 peak p=%0d", p), pg, p);
    chk($sformatf("R3 high p=%0d c=%0d", p, c), ah, 2 * (p - c));
    chk($sformatf("R4 compl p=%0d c=%0d", p, c), bm, 0);
  endtask

  task automatic t_shadow_cmp();
    int g, ah, bh, bm, pg;
    meas(3, 2'd1, 16'd2, g, ah, bh, bm, pg);
    chk("R5 old cmp kept", ah, 12);
    meas(-1, 0, 0, g, ah, bh, bm, pg);
    chk("R5 new cmp applied", ah, 16);
  endtask

  task automatic t_shadow_prd();
    int g, ah, bh, bm, pg;
    meas(8, 2'd0, 16'd4, g, ah, bh, bm, pg);
    chk("R6 old period kept", g, 20);
    meas(-1, 0, 0, g, ah, bh, bm, pg);
    chk("R6 new period applied", g, 8);
    chk("R6 new period duty", ah, 4);
  endtask

  task automatic t_div(input int sa, input int sb);
    int g, ah, bh, bm, pg;
    int d = (1 << sa) * (1 << sb);
    wr(2'd2, 16'(sa | (sb << 3)));
    meas(-1, 0, 0, g, ah, bh, bm, pg);
    meas(-1, 0, 0, g, ah, bh, bm, pg);
    meas(-1, 0, 0, g, ah, bh, bm, pg);
    chk($sformatf("R7 gap s1=%0d s2=%0d", sa, sb), g, 8 * d);
    chk($sformatf("R7 high s1=%0d s2=%0d", sa, sb), ah, 4 * d);
    chk($sformatf("R7 peak s1=%0d s2=%0d", sa, sb), pg, 4 * d);
  endtask

  task automatic t_irq(input int n);
    int z = 0;
    int bad_align = 0;
    wr(2'd3, 16'(n));
    do @(negedge clk); while (!irq);
    do begin
      @(negedge clk);
      if (zero_evt) z++;
      if (irq && !zero_evt) bad_align++;
    end while (!irq);
    chk($sformatf("R8 zero count n=%0d", n), z, n);
    chk($sformatf("R8 align n=%0d", n), bad_align, 0);
  endtask

  task automatic t_nomatch(input int c);
    int g, ah, bh, bm, pg;
    wr(2'd1, 16'(c));
    meas(-1, 0, 0, g, ah, bh, bm, pg);
    meas(-1, 0, 0, g, ah, bh, bm, pg);
    meas(-1, 0, 0, g, ah, bh, bm, pg);
    chk($sformatf("R9 a held low c=%0d", c), ah, 0);
    chk($sformatf("R9 b held high c=%0d", c), bh, g);
  endtask

  task automatic t_default();
    int g, ah, bh, bm, pg;
    wr(2'd2, 16'd0);
    wait_zero();
    meas(-1, 0, 0, g, ah, bh, bm, pg);
    chk("R10 default period", g, 12000);
    chk("R10 default duty", ah, 6000);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_default();
    t_duty(10, 4);
    t_duty(10, 1);
    t_duty(10, 9);
    t_duty(7, 3);
    wr(2'd0, 16'd10);
    wr(2'd1, 16'd4);
    wait_zero();
    wait_zero();
    t_shadow_cmp();
    wr(2'd1, 16'd2);
    wait_zero();
    t_shadow_prd();
    t_div(1, 1);
    t_div(2, 0);
    t_div(0, 1);
    t_div(2, 1);
    wr(2'd2, 16'd0);
    t_irq(3);
    t_irq(2);
    t_irq(1);
    t_nomatch(0);
    t_nomatch(4);
    t_nomatch(9);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1900000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule